// File: doc/BRIEF.md
# Serial Byte Receiver with Transition Resynchronization

This block receives asynchronous serial bytes in the 8N1 format: one low start bit, eight data bits sent least significant bit first, and one high stop bit. It runs from a single system clock. A two-bit select input picks one of four bit periods, each given in clock cycles by a parameter. The defaults give 9600, 19200, 38400 and 57600 baud from a 50 MHz clock.

The serial input first passes through a synchronizer. A two-state tracker then records the last level seen on the line. Whenever the line differs from that recorded level, the tracker flips its state and pulses a restart into the bit-period counter. Each data transition therefore re-aligns the sampling point to the sender's real bit edges. When several equal bits follow one another, there are no transitions, so the counter free-runs and wraps at the bit period to mark each boundary.

A byte that is received cleanly comes out with a one-cycle valid pulse. A stop bit sampled low gives a one-cycle framing-error pulse instead.

Top module: `uart_rx_resync`

## Requirements
- R1: After reset, `rx_valid`, `rx_frame_err` and `rx_data` are all zero. The level tracker starts at the high (idle) level, so a line held high starts no frame and produces no pulse.
- R2: `rate_sel` picks the bit period in clock cycles: value 0 picks DIV0 (5208, 9600 baud), 1 picks DIV1 (2604, 19200 baud), 2 picks DIV2 (1302, 38400 baud) and 3 picks DIV3 (868, 57600 baud).
- R3: A frame is a low start bit, eight data bits received LSB first, and a high stop bit. When the start bit is first driven low on the clock cycle after edge N, and every bit lasts exactly D cycles, `rx_valid` is high for exactly the one cycle after edge N + 9·D + D/2 + 4 (integer division), and `rx_data` then holds the byte.
- R4: Every change of the synchronized line level restarts the bit counter at zero. A sender whose bits are 25 % longer than D is still decoded correctly when every bit boundary carries a transition, for example byte 0x55. With bit length P, the valid pulse then follows edge N + 9·P + D/2 + 4.
- R5: When no transitions occur, the bit counter wraps every D cycles and sampling continues at that spacing. A byte 0x00 sent with 25 % longer bits therefore samples the stop position while the line is still low, and gives a framing error after edge N + 9·D + D/2 + 4.
- R6: A start bit that is low for less than half a bit period is rejected. The receiver returns to idle and produces neither pulse.
- R7: A stop bit sampled low pulses `rx_frame_err` for one cycle, with no valid pulse and `rx_data` left unchanged. `rx_valid` and `rx_frame_err` are never high together.
- R8: A change of `rate_sel` during a frame has no effect on that frame. The new rate takes effect only when the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 2 | Bit-period select (R2 encoding) |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rx_data | output | 8 | Last byte received without error |
| rx_valid | output | 1 | One-cycle pulse when a good byte is received |
| rx_frame_err | output | 1 | One-cycle pulse when the stop bit is sampled low |

## Verification
The result of each frame is due at a fixed number of cycles after the start bit is driven. That number is two synchronizer stages, one cycle for the restart, half a bit to the first sample point, then nine bit periods and one register for the output: N + 9·D + D/2 + 4. For stretched frames whose boundaries all carry transitions, the bit length P replaces D in the 9·D term. The bench drives each bit one time unit after a rising edge and keeps a cycle index. A monitor reads both pulses on the falling edge and stamps each one with that index. Every frame is then checked for its data value and for the exact cycle of its valid or error pulse, and rejected or ignored stimulus is checked by counting pulses over a window that outlasts any pulse it could cause.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   // Level tracker encoding: one-hot, so any other code is illegal
   typedef enum logic [1:0] {
      LVL_HIGH = 2'b01,
      LVL_LOW  = 2'b10
   } lvl_e;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP
   } rx_st_e;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("uart_rx_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) chain[i] <= 1'b1;
            else if (i == 0) chain[i] <= din;
            else chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/uart_rx_level_track.sv
module uart_rx_level_track
   import uart_rx_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic line,
   output logic restart,
   output logic level_high
);

   lvl_e lvl_q, lvl_d;

   always_comb begin
      restart = 1'b0;
      lvl_d   = lvl_q;
      case (lvl_q)
         LVL_HIGH: if (!line) begin
            restart = 1'b1;
            lvl_d   = LVL_LOW;
         end
         LVL_LOW: if (line) begin
            restart = 1'b1;
            lvl_d   = LVL_HIGH;
         end
         default: begin
            // illegal code: recover to idle level, no restart
            restart = 1'b0;
            lvl_d   = LVL_HIGH;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) lvl_q <= LVL_HIGH;
      else     lvl_q <= lvl_d;
   end

   assign level_high = (lvl_q == LVL_HIGH);

endmodule

// File: rtl/uart_rx_bit_timer.sv
module uart_rx_bit_timer #(
   parameter int CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart,
   input  logic [CNT_W-1:0] div,
   output logic [CNT_W-1:0] cnt,
   output logic             mid_tick
);

   logic [CNT_W-1:0] half;
   logic [CNT_W-1:0] last;

   assign half = div >> 1;
   assign last = div - 1'b1;

   always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (restart)     cnt <= '0;
      else if (cnt >= last) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   assign mid_tick = (cnt == half);

endmodule

// File: rtl/uart_rx_resync.sv
module uart_rx_resync
   import uart_rx_pkg::*;
#(
   parameter int DIV0        = 5208,
   parameter int DIV1        = 2604,
   parameter int DIV2        = 1302,
   parameter int DIV3        = 868,
   parameter int DATA_BITS   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [1:0]           rate_sel,
   input  logic                 rxd,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_valid,
   output logic                 rx_frame_err
);

   localparam int DIV_MAX = max4(DIV0, DIV1, DIV2, DIV3);
   localparam int CNT_W   = $clog2(DIV_MAX + 1);
   localparam int IDX_W   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

   generate
      if (DIV0 < 4 || DIV1 < 4 || DIV2 < 4 || DIV3 < 4) begin : g_div_chk
         $error("uart_rx_resync: every divisor must be at least 4");
      end
      if (DATA_BITS < 1) begin : g_bits_chk
         $error("uart_rx_resync: DATA_BITS must be positive");
      end
   endgenerate

   logic             line_s;
   logic             restart;
   logic             level_high;
   logic [CNT_W-1:0] cnt;
   logic             mid_tick;
   logic [CNT_W-1:0] sel_div;
   logic [CNT_W-1:0] div_q;
   logic             busy;

   rx_st_e                 st_q;
   logic [DATA_BITS-1:0]   shreg;
   logic [IDX_W-1:0]       bit_idx;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (rxd),
      .dout (line_s)
   );

   uart_rx_level_track u_lvl (
      .clk        (clk),
      .rst        (rst),
      .line       (line_s),
      .restart    (restart),
      .level_high (level_high)
   );

   uart_rx_bit_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .restart  (restart),
      .div      (div_q),
      .cnt      (cnt),
      .mid_tick (mid_tick)
   );

   always_comb begin
      case (rate_sel)
         2'd0:    sel_div = CNT_W'(DIV0);
         2'd1:    sel_div = CNT_W'(DIV1);
         2'd2:    sel_div = CNT_W'(DIV2);
         default: sel_div = CNT_W'(DIV3);
      endcase
   end

   assign busy = (st_q != RX_IDLE);

   // rate is latched only while idle
   always_ff @(posedge clk) begin
      if (rst)        div_q <= CNT_W'(DIV0);
      else if (!busy) div_q <= sel_div;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q         <= RX_IDLE;
         shreg        <= '0;
         bit_idx      <= '0;
         rx_data      <= '0;
         rx_valid     <= 1'b0;
         rx_frame_err <= 1'b0;
      end else begin
         rx_valid     <= 1'b0;
         rx_frame_err <= 1'b0;
         case (st_q)
            RX_IDLE: if (restart && !line_s) st_q <= RX_START;
            RX_START: if (mid_tick) begin
               bit_idx <= '0;
               st_q    <= line_s ? RX_IDLE : RX_DATA;
            end
            RX_DATA: if (mid_tick) begin
               shreg <= {line_s, shreg[DATA_BITS-1:1]};
               if (bit_idx == IDX_W'(DATA_BITS-1)) st_q <= RX_STOP;
               else bit_idx <= bit_idx + 1'b1;
            end
            RX_STOP: if (mid_tick) begin
               if (line_s) begin
                  rx_valid <= 1'b1;
                  rx_data  <= shreg;
               end else begin
                  rx_frame_err <= 1'b1;
               end
               st_q <= RX_IDLE;
            end
            default: st_q <= RX_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/uart_rx_resync_chk.sv
module uart_rx_resync_chk #(
   parameter int CNT_W = 13
) (
   input logic             clk,
   input logic             rst,
   input logic             line_s,
   input logic             restart,
   input logic             level_high,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] div_q,
   input logic             busy,
   input logic             rx_valid,
   input logic             rx_frame_err
);

   assert_reset_idle_level_R1: assert property (@(posedge clk)
      $past(rst) |-> level_high);

   assert_restart_zeroes_timer_R4: assert property (@(posedge clk) disable iff (rst)
      restart |=> (cnt == '0));

   assert_tracker_follows_line_R4: assert property (@(posedge clk) disable iff (rst)
      restart |=> (level_high == $past(line_s)));

   assert_timer_in_period_R5: assert property (@(posedge clk) disable iff (rst)
      busy |-> (cnt < div_q));

   assert_valid_single_R3: assert property (@(posedge clk) disable iff (rst)
      rx_valid |=> !rx_valid);

   assert_pulses_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
      !(rx_valid && rx_frame_err));

   assert_rate_frozen_R8: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> $stable(div_q));

endmodule

bind uart_rx_resync uart_rx_resync_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .line_s       (line_s),
   .restart      (restart),
   .level_high   (level_high),
   .cnt          (cnt),
   .div_q        (div_q),
   .busy         (busy),
   .rx_valid     (rx_valid),
   .rx_frame_err (rx_frame_err)
);

// File: tb/uart_rx_resync_test.sv
module uart_rx_resync_test;

   localparam int D0 = 40, D1 = 24, D2 = 16, D3 = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] rate_sel = 2'd3;
   logic       rxd = 1'b1;
   logic [7:0] rx_data;
   logic       rx_valid, rx_frame_err;

   int cyc = 0;
   int n_chk = 0, n_fail = 0;
   int v_cnt = 0, v_cyc = 0, f_cnt = 0, f_cyc = 0;
   logic [7:0] v_dat = 8'h00;

   uart_rx_resync #(.DIV0(D0), .DIV1(D1), .DIV2(D2), .DIV3(D3)) uut (
      .clk(clk), .rst(rst), .rate_sel(rate_sel), .rxd(rxd),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rx_valid) begin v_cnt++; v_cyc = cyc; v_dat = rx_data; end
      if (rx_frame_err) begin f_cnt++; f_cyc = cyc; end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int div_of(input logic [1:0] s);
      case (s)
         2'd0: return D0;
         2'd1: return D1;
         2'd2: return D2;
         default: return D3;
      endcase
   endfunction

   task automatic send(input logic [7:0] b, input int p, input logic stop_bit, output int n);
      @(posedge clk); #1;
      n = cyc;
      rxd = 1'b0;
      repeat (p) @(posedge clk);
      for (int i = 0; i < 8; i++) begin
         #1 rxd = b[i];
         repeat (p) @(posedge clk);
      end
      #1 rxd = stop_bit;
      repeat (p) @(posedge clk);
      #1 rxd = 1'b1;
      repeat (p + 4) @(posedge clk);
   endtask

   task automatic frame_ok(input logic [7:0] b, input int p, input int d, input string req);
      int n, vc;
      vc = v_cnt;
      send(b, p, 1'b1, n);
      check(v_cnt == vc + 1 && v_dat == b, req, v_dat, b);
      check(v_cyc == n + 9*p + d/2 + 4, req, v_cyc - n, 9*p + d/2 + 4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int n, vc, fc;
      logic [7:0] last;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      repeat (3*D0) @(posedge clk);
      #1;
      // R1: reset state, idle line starts nothing
      check(rx_data == 8'h00 && !rx_valid && !rx_frame_err, "R1", rx_data, 0);
      check(v_cnt == 0 && f_cnt == 0, "R1", v_cnt + f_cnt, 0);

      // R3: every byte at the fastest rate
      rate_sel = 2'd3;
      for (int b = 0; b < 256; b++) frame_ok(8'(b), D3, D3, "R3");

      // R2: each select value gives its own period
      for (int s = 0; s < 4; s++) begin
         rate_sel = 2'(s);
         frame_ok(8'h3C ^ 8'(s), div_of(2'(s)), div_of(2'(s)), "R2");
         frame_ok(8'h81, div_of(2'(s)), div_of(2'(s)), "R2");
      end

      // R4: slow sender, transitions at each boundary
      rate_sel = 2'd3;
      frame_ok(8'h55, D3 + D3/4, D3, "R4");

      // R5: slow sender, no transitions, counter free-runs
      vc = v_cnt; fc = f_cnt;
      send(8'h00, D3 + D3/4, 1'b1, n);
      check(f_cnt == fc + 1 && v_cnt == vc, "R5", f_cnt - fc, 1);
      check(f_cyc == n + 9*D3 + D3/2 + 4, "R5", f_cyc - n, 9*D3 + D3/2 + 4);

      // R6: short start glitch
      vc = v_cnt; fc = f_cnt;
      @(posedge clk); #1 rxd = 1'b0;
      repeat (2) @(posedge clk); #1 rxd = 1'b1;
      repeat (20*D3) @(posedge clk); #1;
      check(v_cnt == vc && f_cnt == fc, "R6", v_cnt + f_cnt - vc - fc, 0);
      frame_ok(8'h96, D3, D3, "R6");

      // R7: low stop bit
      last = rx_data;
      vc = v_cnt; fc = f_cnt;
      send(8'hA5, D3, 1'b0, n);
      check(f_cnt == fc + 1 && v_cnt == vc, "R7", f_cnt - fc, 1);
      check(f_cyc == n + 9*D3 + D3/2 + 4, "R7", f_cyc - n, 9*D3 + D3/2 + 4);
      check(rx_data == last, "R7", rx_data, last);

      // R8: select changed mid-frame
      rate_sel = 2'd3;
      fork
         frame_ok(8'hC3, D3, D3, "R8");
         begin repeat (30) @(posedge clk); #2 rate_sel = 2'd0; end
      join
      frame_ok(8'h5A, D0, D0, "R8");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule